// File: doc/BRIEF.md
# Rate-Paced GPIO FIFO Port

This block moves data between a host and a parallel group of external pins at a fixed pace instead of at the pace of the internal bus. Every timed event comes from one tick, which a programmable baud divider produces. The host can queue several words in a four-entry write queue without waiting. One queued word goes out onto the output pins at each tick.

On the read side there are two paths. A background sampler takes a start command and a sample count. It then captures the input pins once per tick into an eight-entry read queue, and the host drains that queue whenever it likes. A blocking read holds the requester until a sample is taken. That sample is taken only after all queued writes have left the pins.

Status outputs give the number of pending writes, a busy flag for the word now on the pins, and a combined idle flag. A new access may start when idle is set.

Top module: `gpio_rate_port`

## Requirements
- R1: With baud value N, rate ticks come exactly N+1 clock cycles apart, so consecutive pin updates and consecutive samples are N+1 cycles apart. N=0 gives a tick every clock.
- R2: The write queue holds 4 words. Writes into a non-full queue are accepted back to back with `wr_ready_o` high. While 4 words are pending, `wr_ready_o` is low and the offered word is held, never dropped.
- R3: At each tick the oldest queued word is driven onto `pins_o`, in write order. Between ticks `pins_o` does not change.
- R4: `wr_pending_o` gives the number of queued words. `wr_busy_o` stays set from a drain tick until the next tick that finds the queue empty. `idle_o` is high only when the pending count is zero and busy is clear, so it rises exactly N+1 cycles after the last word reaches the pins.
- R5: A `nb_start_i` pulse with count C makes the sampler capture `pins_i` on each of the next C ticks and then stop by itself. `nb_active_o` is high while sampling, and C=0 captures nothing.
- R6: The read queue holds 8 samples. `rd_data_o` shows the oldest sample and `rd_pop_i` removes it, so samples come out in capture order. `rd_level_o` counts the entries and `rd_empty_o` flags zero.
- R7: A sample taken while the read queue is full is discarded and sets `ovf_o`. `ovf_o` stays set until `ovf_clr_i` is pulsed, and a new overflow in that same cycle wins over the clear.
- R8: A held `blk_req_i` is served on the first tick at which the port is idle. `pins_i` is captured into `blk_data_o` and `blk_ack_o` pulses for exactly one cycle.
- R9: After reset `pins_o` is 0, both queues are empty, `wr_ready_o` and `idle_o` are 1, and busy, overflow, active and ack are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_i | input | 16 | Divider reload value N; tick period is N+1 |
| wr_valid_i | input | 1 | Host offers a write word |
| wr_data_i | input | 8 | Write word |
| wr_ready_o | output | 1 | Write queue can accept |
| pins_o | output | 8 | Output pin group |
| wr_pending_o | output | 3 | Number of queued write words |
| wr_busy_o | output | 1 | A drained word still owns its tick slot |
| idle_o | output | 1 | No pending write and not busy |
| pins_i | input | 8 | Input pin group |
| nb_start_i | input | 1 | Start background sampling |
| nb_count_i | input | 16 | Number of background samples |
| nb_active_o | output | 1 | Background sampling in progress |
| rd_pop_i | input | 1 | Remove the oldest sample |
| rd_data_o | output | 8 | Oldest sample |
| rd_empty_o | output | 1 | Read queue empty |
| rd_level_o | output | 4 | Read queue entries |
| ovf_o | output | 1 | Sticky read overflow |
| ovf_clr_i | input | 1 | Clear overflow |
| blk_req_i | input | 1 | Blocking read request, held until ack |
| blk_ack_o | output | 1 | One-cycle completion of a blocking read |
| blk_data_o | output | 8 | Blocking read sample |

## Verification
A word accepted at one clock edge appears on `pins_o` after the first tick edge that follows. Later words follow every N+1 cycles, and `idle_o` rises N+1 cycles after the last word. A sample is captured at a tick edge, and a blocking read's ack and data are visible right after the tick edge that captures them. The tick phase is not known to the bench, so a monitor records the cycle number 2 ns after each rising edge at which `pins_o` or `idle_o` changes. The checks then compare differences between those cycle numbers, and differences between sampled counter values driven on `pins_i`, against N+1. Inputs change only on falling edges, and static outputs are read there.

// File: rtl/gpio_rate_pkg.sv
package gpio_rate_pkg;
  localparam int unsigned DEF_DW       = 8;
  localparam int unsigned DEF_BAUD_W   = 16;
  localparam int unsigned DEF_WR_DEPTH = 4;
  localparam int unsigned DEF_RD_DEPTH = 8;
  localparam int unsigned DEF_NB_CW    = 16;
endpackage

// File: rtl/gpio_rate_tick.sv
module gpio_rate_tick #(
  parameter int unsigned BAUD_W = gpio_rate_pkg::DEF_BAUD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BAUD_W-1:0] baud_i,
  output logic              tick_o
);
  logic [BAUD_W-1:0] cnt_q;

  assign tick_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= baud_i;
    else             cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/gpio_rate_fifo.sv
// Show-ahead queue; DEPTH must be a power of two.
module gpio_rate_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] lvl_q;
  logic          push_ok, pop_ok;

  assign full_o  = (lvl_q == CW'(DEPTH));
  assign empty_o = (lvl_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign data_o  = mem_q[rp_q];
  assign level_o = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (push_ok) wp_q <= wp_q + 1'b1;
      if (pop_ok)  rp_q <= rp_q + 1'b1;
      lvl_q <= lvl_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wp_q] <= data_i;
  end
endmodule

// File: rtl/gpio_rate_wr.sv
module gpio_rate_wr #(
  parameter int unsigned DW    = gpio_rate_pkg::DEF_DW,
  parameter int unsigned DEPTH = gpio_rate_pkg::DEF_WR_DEPTH,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_valid_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          wr_ready_o,
  output logic [DW-1:0] pins_o,
  output logic [CW-1:0] pending_o,
  output logic          busy_o
);
  logic [DW-1:0] head;
  logic          full, empty, drain;

  assign wr_ready_o = !full;
  assign drain      = tick_i && !empty;

  gpio_rate_fifo #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (wr_valid_i),
    .data_i  (wr_data_i),
    .pop_i   (drain),
    .data_o  (head),
    .level_o (pending_o),
    .full_o  (full),
    .empty_o (empty)
  );

  // busy covers the whole tick slot of the word last driven
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pins_o <= '0;
      busy_o <= 1'b0;
    end else if (tick_i) begin
      busy_o <= !empty;
      if (!empty) pins_o <= head;
    end
  end
endmodule

// File: rtl/gpio_rate_rd.sv
module gpio_rate_rd #(
  parameter int unsigned DW    = gpio_rate_pkg::DEF_DW,
  parameter int unsigned DEPTH = gpio_rate_pkg::DEF_RD_DEPTH,
  parameter int unsigned NB_CW = gpio_rate_pkg::DEF_NB_CW,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [DW-1:0]    pins_i,
  input  logic             start_i,
  input  logic [NB_CW-1:0] count_i,
  output logic             active_o,
  input  logic             pop_i,
  output logic [DW-1:0]    data_o,
  output logic             empty_o,
  output logic [CW-1:0]    level_o,
  output logic             ovf_o,
  input  logic             ovf_clr_i
);
  logic [NB_CW-1:0] remain_q;
  logic             sample, full;

  assign sample = active_o && tick_i;

  gpio_rate_fifo #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (sample),
    .data_i  (pins_i),
    .pop_i   (pop_i),
    .data_o  (data_o),
    .level_o (level_o),
    .full_o  (full),
    .empty_o (empty_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain_q <= '0;
      active_o <= 1'b0;
    end else if (start_i) begin
      remain_q <= count_i;
      active_o <= (count_i != '0);
    end else if (sample) begin
      remain_q <= remain_q - 1'b1;
      if (remain_q == NB_CW'(1)) active_o <= 1'b0;
    end
  end

  // set beats clear so no overflow event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ovf_o <= 1'b0;
    else if (sample && full)  ovf_o <= 1'b1;
    else if (ovf_clr_i)       ovf_o <= 1'b0;
  end
endmodule

// File: rtl/gpio_rate_port.sv
module gpio_rate_port #(
  parameter int unsigned DW       = gpio_rate_pkg::DEF_DW,
  parameter int unsigned BAUD_W   = gpio_rate_pkg::DEF_BAUD_W,
  parameter int unsigned WR_DEPTH = gpio_rate_pkg::DEF_WR_DEPTH,
  parameter int unsigned RD_DEPTH = gpio_rate_pkg::DEF_RD_DEPTH,
  parameter int unsigned NB_CW    = gpio_rate_pkg::DEF_NB_CW,
  parameter int unsigned WR_CW    = $clog2(WR_DEPTH + 1),
  parameter int unsigned RD_CW    = $clog2(RD_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BAUD_W-1:0] baud_i,
  input  logic              wr_valid_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic              wr_ready_o,
  output logic [DW-1:0]     pins_o,
  output logic [WR_CW-1:0]  wr_pending_o,
  output logic              wr_busy_o,
  output logic              idle_o,
  input  logic [DW-1:0]     pins_i,
  input  logic              nb_start_i,
  input  logic [NB_CW-1:0]  nb_count_i,
  output logic              nb_active_o,
  input  logic              rd_pop_i,
  output logic [DW-1:0]     rd_data_o,
  output logic              rd_empty_o,
  output logic [RD_CW-1:0]  rd_level_o,
  output logic              ovf_o,
  input  logic              ovf_clr_i,
  input  logic              blk_req_i,
  output logic              blk_ack_o,
  output logic [DW-1:0]     blk_data_o
);
  logic tick_w;

  gpio_rate_tick #(.BAUD_W(BAUD_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .baud_i (baud_i),
    .tick_o (tick_w)
  );

  gpio_rate_wr #(.DW(DW), .DEPTH(WR_DEPTH), .CW(WR_CW)) u_wr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_w),
    .wr_valid_i (wr_valid_i),
    .wr_data_i  (wr_data_i),
    .wr_ready_o (wr_ready_o),
    .pins_o     (pins_o),
    .pending_o  (wr_pending_o),
    .busy_o     (wr_busy_o)
  );

  assign idle_o = (wr_pending_o == '0) && !wr_busy_o;

  gpio_rate_rd #(.DW(DW), .DEPTH(RD_DEPTH), .NB_CW(NB_CW), .CW(RD_CW)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_w),
    .pins_i    (pins_i),
    .start_i   (nb_start_i),
    .count_i   (nb_count_i),
    .active_o  (nb_active_o),
    .pop_i     (rd_pop_i),
    .data_o    (rd_data_o),
    .empty_o   (rd_empty_o),
    .level_o   (rd_level_o),
    .ovf_o     (ovf_o),
    .ovf_clr_i (ovf_clr_i)
  );

  // blocking read: ordered behind queued writes, one capture per request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_ack_o  <= 1'b0;
      blk_data_o <= '0;
    end else if (tick_w && blk_req_i && idle_o && !blk_ack_o) begin
      blk_ack_o  <= 1'b1;
      blk_data_o <= pins_i;
    end else begin
      blk_ack_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_rate_port_chk.sv
module gpio_rate_port_chk #(
  parameter int unsigned DW       = 8,
  parameter int unsigned WR_DEPTH = 4,
  parameter int unsigned RD_DEPTH = 8,
  parameter int unsigned WR_CW    = 3,
  parameter int unsigned RD_CW    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             wr_ready_o,
  input logic [WR_CW-1:0] wr_pending_o,
  input logic             wr_busy_o,
  input logic             idle_o,
  input logic [DW-1:0]    pins_o,
  input logic             nb_active_o,
  input logic             nb_start_i,
  input logic             rd_pop_i,
  input logic [RD_CW-1:0] rd_level_o,
  input logic             ovf_o,
  input logic             ovf_clr_i,
  input logic             blk_ack_o
);
  p_full_stalls_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pending_o == WR_CW'(WR_DEPTH)) |-> !wr_ready_o);

  p_pending_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pending_o <= WR_CW'(WR_DEPTH));

  p_pins_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(pins_o));

  p_idle_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (wr_pending_o == '0) && !wr_busy_o);

  p_no_sample_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nb_active_o && !nb_start_i && !rd_pop_i) |=> $stable(rd_level_o));

  p_level_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_level_o <= RD_CW'(RD_DEPTH));

  p_ovf_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);

  p_ack_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_ack_o |=> !blk_ack_o);

  p_ack_after_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(blk_ack_o) |-> $past(idle_o) && $past(tick_i));
endmodule

bind gpio_rate_port gpio_rate_port_chk #(
  .DW(DW), .WR_DEPTH(WR_DEPTH), .RD_DEPTH(RD_DEPTH), .WR_CW(WR_CW), .RD_CW(RD_CW)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_w),
  .wr_ready_o   (wr_ready_o),
  .wr_pending_o (wr_pending_o),
  .wr_busy_o    (wr_busy_o),
  .idle_o       (idle_o),
  .pins_o       (pins_o),
  .nb_active_o  (nb_active_o),
  .nb_start_i   (nb_start_i),
  .rd_pop_i     (rd_pop_i),
  .rd_level_o   (rd_level_o),
  .ovf_o        (ovf_o),
  .ovf_clr_i    (ovf_clr_i),
  .blk_ack_o    (blk_ack_o)
);

// File: tb/gpio_rate_port_test.sv
`timescale 1ns/1ps
module gpio_rate_port_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] baud = 0;
  logic        wr_valid = 0;
  logic [7:0]  wr_data = 0;
  logic        wr_ready;
  logic [7:0]  pins_o;
  logic [2:0]  wr_pending;
  logic        wr_busy, idle;
  logic [7:0]  pins_i = 0;
  logic        nb_start = 0;
  logic [15:0] nb_count = 0;
  logic        nb_active;
  logic        rd_pop = 0;
  logic [7:0]  rd_data;
  logic        rd_empty;
  logic [3:0]  rd_level;
  logic        ovf, ovf_clr = 0;
  logic        blk_req = 0, blk_ack;
  logic [7:0]  blk_data;

  gpio_rate_port uut (
    .clk_i(clk), .rst_ni(rst_n), .baud_i(baud),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_ready_o(wr_ready),
    .pins_o(pins_o), .wr_pending_o(wr_pending), .wr_busy_o(wr_busy), .idle_o(idle),
    .pins_i(pins_i), .nb_start_i(nb_start), .nb_count_i(nb_count), .nb_active_o(nb_active),
    .rd_pop_i(rd_pop), .rd_data_o(rd_data), .rd_empty_o(rd_empty), .rd_level_o(rd_level),
    .ovf_o(ovf), .ovf_clr_i(ovf_clr),
    .blk_req_i(blk_req), .blk_ack_o(blk_ack), .blk_data_o(blk_data)
  );

  always #4 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  bit cnt_mode = 0;
  logic [7:0] fix_val = 8'h5A;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) pins_i <= cnt_mode ? cyc[7:0] : fix_val;

  // change monitor, 2 ns after the edge
  int mon_n = 0, idle_rise = 0;
  int chg_cyc [16];
  logic [7:0] chg_val [16];
  logic [7:0] last_pins = 0;
  logic last_idle = 1;
  always begin
    @(posedge clk); #2;
    if (pins_o !== last_pins) begin
      if (mon_n < 16) begin chg_val[mon_n] = pins_o; chg_cyc[mon_n] = cyc; end
      mon_n++;
      last_pins = pins_o;
    end
    if (idle && !last_idle) idle_rise = cyc;
    last_idle = idle;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) if (cyc == 150000) begin
    fails++;
    $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  int stalls;
  task automatic push_word(input logic [7:0] d);
    wr_valid = 1; wr_data = d;
    while (!wr_ready) begin
      stalls++;
      chk(wr_pending == 3'd4, "R2", "stall only when full", wr_pending, 4);
      @(negedge clk);
    end
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic wait_idle();
    while (!(idle && wr_pending == 0)) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic pop_one(output logic [7:0] d);
    d = rd_data; rd_pop = 1;
    @(negedge clk); rd_pop = 0;
  endtask

  // {baud, seed}; row words are seed + i*0x11
  localparam logic [23:0] VEC [4] = '{24'h000010, 24'h000350, 24'h000190, 24'h0005C0};

  logic [15:0] b;
  logic [7:0]  seed, d0, d1;

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(pins_o == 0 && wr_ready && idle && !wr_busy && wr_pending == 0, "R9", "write side reset", pins_o, 0);
    chk(rd_empty && rd_level == 0 && !ovf && !nb_active && !blk_ack, "R9", "read side reset", rd_level, 0);
    rst_n = 1;
    @(negedge clk);

    for (int r = 0; r < 4; r++) begin
      b = VEC[r][23:8]; seed = VEC[r][7:0];
      wait_idle();
      baud = b;
      repeat (8) @(negedge clk);
      mon_n = 0; stalls = 0;
      for (int i = 0; i < 4; i++) push_word(seed + 8'(i * 8'h11));
      chk(stalls == 0, "R2", "back-to-back accept", stalls, 0);
      wait_idle();
      chk(mon_n == 4, "R3", "pin update count", mon_n, 4);
      for (int i = 0; i < 4; i++)
        chk(chg_val[i] == seed + 8'(i * 8'h11), "R3", "pin order", chg_val[i], seed + i * 8'h11);
      for (int i = 0; i < 3; i++)
        chk(chg_cyc[i+1] - chg_cyc[i] == int'(b) + 1, "R1", "pin spacing", chg_cyc[i+1] - chg_cyc[i], b + 1);
      chk(idle_rise - chg_cyc[3] == int'(b) + 1, "R4", "idle after busy slot", idle_rise - chg_cyc[3], b + 1);
    end

    // R2 full queue holds the writer, nothing dropped
    baud = 20;
    repeat (8) @(negedge clk);
    mon_n = 0; stalls = 0;
    for (int i = 0; i < 6; i++) push_word(8'hA0 + 8'(i));
    chk(stalls > 0, "R2", "writer held when full", stalls, 1);
    wait_idle();
    chk(mon_n == 6, "R2", "no word dropped", mon_n, 6);
    for (int i = 0; i < 6; i++)
      chk(chg_val[i] == 8'hA0 + 8'(i), "R2", "held word order", chg_val[i], 8'hA0 + i);

    // R5 background sampling for a count
    cnt_mode = 1; baud = 2;
    repeat (8) @(negedge clk);
    nb_count = 5; nb_start = 1;
    @(negedge clk); nb_start = 0;
    chk(nb_active, "R5", "active after start", nb_active, 1);
    repeat (40) @(negedge clk);
    chk(!nb_active, "R5", "stops by itself", nb_active, 0);
    chk(rd_level == 5, "R5", "sample count", rd_level, 5);
    pop_one(d0);
    for (int i = 0; i < 4; i++) begin
      pop_one(d1);
      chk(8'(d1 - d0) == 8'd3, "R1", "sample spacing", 8'(d1 - d0), 3);
      d0 = d1;
    end
    chk(rd_empty && rd_level == 0, "R6", "drained", rd_level, 0);

    // R5 zero count
    nb_count = 0; nb_start = 1;
    @(negedge clk); nb_start = 0;
    repeat (10) @(negedge clk);
    chk(rd_level == 0 && !nb_active, "R5", "count 0 samples nothing", rd_level, 0);

    // R6/R7 overflow
    baud = 0;
    repeat (8) @(negedge clk);
    nb_count = 11; nb_start = 1;
    @(negedge clk); nb_start = 0;
    repeat (20) @(negedge clk);
    chk(rd_level == 8, "R6", "depth 8", rd_level, 8);
    chk(ovf, "R7", "overflow set", ovf, 1);
    pop_one(d0);
    for (int i = 0; i < 7; i++) begin
      pop_one(d1);
      chk(8'(d1 - d0) == 8'd1, "R6", "capture order kept", 8'(d1 - d0), 1);
      d0 = d1;
    end
    chk(ovf, "R7", "overflow sticky", ovf, 1);
    ovf_clr = 1;
    @(negedge clk); ovf_clr = 0;
    chk(!ovf, "R7", "overflow cleared", ovf, 0);

    // R8 blocking read waits behind writes
    cnt_mode = 0; fix_val = 8'h5A; baud = 10;
    repeat (12) @(negedge clk);
    push_word(8'h11); push_word(8'h22);
    chk(!idle, "R4", "not idle with writes queued", idle, 0);
    blk_req = 1;
    while (!blk_ack) @(negedge clk);
    chk(idle && wr_pending == 0, "R8", "ack only when idle", wr_pending, 0);
    chk(pins_o == 8'h22, "R8", "writes out before read", pins_o, 8'h22);
    chk(blk_data == 8'h5A, "R8", "blocking data", blk_data, 8'h5A);
    blk_req = 0;
    @(negedge clk);
    chk(!blk_ack, "R8", "single-cycle ack", blk_ack, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule